// File: doc/BRIEF.md
# Single-Slot Address Translation Cache

This block keeps one cached virtual-to-physical translation next to a page-table walker. The walker installs a translation once a walk succeeds. The load/store path then probes the slot with an address-space identifier and a virtual address. A probe is purely combinational. On a hit it returns a translated physical address together with every stored field of the entry.

The slot records several fields:
- the leaf level (0 is a 4 KiB page; 1, 2 and 3 are superpages spanning 9, 18 and 27 extra bits of page number);
- a global flag;
- the 16-bit identifier;
- the full 48-bit virtual address;
- the 56-bit physical address;
- the 64-bit page-table entry;
- the address the entry was read from.

Probes compare only the page-number bits that the leaf level does not cover. Invalidation requests can be filtered by identifier, by page number, by both, or by neither.

There is one slot, so any install overwrites the previous entry. Probes never change state.

Top module: `xlat_slot_cache`

## Requirements
- R1: After a synchronous reset the slot is empty, and every probe misses until the next install.
- R2: An install (`ins_en` high at a rising edge) stores all entry fields and marks the slot valid. The new entry is visible to probes from the next cycle and fully replaces any earlier entry.
- R3: A probe hits when three conditions hold: the slot is valid; `lk_va[47:12]` equals the stored `va[47:12]` in every bit at or above position 12+9×level; and either `lk_asid` equals the stored identifier or the stored global flag is 1. On a hit, `hit_idx` is 0 and `hit_asid`, `hit_global`, `hit_va`, `hit_leaf_pa`, `hit_pte`, `hit_level` and `hit_pte_addr` carry the stored fields.
- R4: On a miss, `hit` is 0 and every other hit output is driven to zero.
- R5: The hit physical address is built from three parts. Bits [55:12+9×level] come from the stored physical address. Bits [12+9×level-1:12] come from `lk_va`. Bits [11:0] equal `lk_va[11:0]`.
- R6: An invalidation (`fl_en`) with both `fl_asid_vld` and `fl_vpn_vld` low empties the slot unconditionally.
- R7: An invalidation with only `fl_asid_vld` set empties the slot only if the entry is not global and its identifier equals `fl_asid`.
- R8: An invalidation with only `fl_vpn_vld` set empties the slot only if `fl_vpn` matches the entry's page number under the level rule of R3. The identifier and global flag are ignored.
- R9: An invalidation with both filters set empties the slot only when the R7 and R8 conditions both hold.
- R10: When `ins_en` and `fl_en` are high in the same cycle, the install takes effect and the invalidation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_asid | input | 16 | Probe address-space identifier |
| lk_va | input | 48 | Probe virtual address |
| hit | output | 1 | Probe hit |
| hit_idx | output | 1 | Index of hitting slot (always 0) |
| hit_pa | output | 56 | Translated physical address |
| hit_asid | output | 16 | Stored identifier |
| hit_global | output | 1 | Stored global flag |
| hit_va | output | 48 | Stored virtual address |
| hit_leaf_pa | output | 56 | Stored physical address |
| hit_pte | output | 64 | Stored page-table entry |
| hit_level | output | 2 | Stored leaf level |
| hit_pte_addr | output | 56 | Stored page-table-entry address |
| ins_en | input | 1 | Install strobe |
| ins_asid | input | 16 | Install identifier |
| ins_global | input | 1 | Install global flag |
| ins_va | input | 48 | Install virtual address |
| ins_pa | input | 56 | Install physical address |
| ins_pte | input | 64 | Install page-table entry |
| ins_level | input | 2 | Install leaf level |
| ins_pte_addr | input | 56 | Install page-table-entry address |
| fl_en | input | 1 | Invalidate strobe |
| fl_asid_vld | input | 1 | Identifier filter present |
| fl_asid | input | 16 | Identifier filter |
| fl_vpn_vld | input | 1 | Page-number filter present |
| fl_vpn | input | 36 | Page-number filter |

## Verification
Errors in the valid bit or the stored fields show up on the first probe after the faulty edge, because the probe path has no register.

Some faults are visible only at particular levels or for particular entry types:
- A wrong level mask or a wrong stored level becomes a false hit or false miss only for probes that differ from the entry in the masked page-number bits. Superpage probes must therefore vary those bits and also the first bit above them.
- A bad merge of page-number bits appears only on superpage hits.
- A filter fault leaves the slot valid, or empties it, one edge after the invalidation strobe. The next probe exposes it as a hit or a miss.
- A global entry that is wrongly dropped by an identifier-only invalidation appears the same way.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    parameter int ASID_W   = 16;
    parameter int VA_W     = 48;
    parameter int PA_W     = 56;
    parameter int PTE_W    = 64;
    parameter int OFS_W    = 12;
    parameter int LVL_BITS = 9;
    parameter int LEVELS   = 4;
    parameter int SLOTS    = 1;

    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam int LVL_W = $clog2(LEVELS);
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef logic [ASID_W-1:0] asid_t;
    typedef logic [VA_W-1:0]   va_t;
    typedef logic [PA_W-1:0]   pa_t;
    typedef logic [PTE_W-1:0]  pte_t;
    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PPN_W-1:0]  ppn_t;
    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    typedef struct packed {
        asid_t asid;
        logic  glb;
        va_t   va;
        pa_t   pa;
        pte_t  pte;
        lvl_t  lvl;
        pa_t   pte_addr;
    } xlat_ent_t;

    // filter selection for an invalidation request
    typedef enum logic [1:0] {
        FL_ALL  = 2'b00,
        FL_VPN  = 2'b01,
        FL_ASID = 2'b10,
        FL_BOTH = 2'b11
    } fl_kind_e;

    // page-number bits that must agree for a given leaf level
    function automatic vpn_t upper_vpn_mask(input lvl_t lvl);
        vpn_t m;
        m = '1;
        m = m << (int'(lvl) * LVL_BITS);
        return m;
    endfunction

    // physical page-number bits that come from the probe address
    function automatic ppn_t low_ppn_mask(input lvl_t lvl);
        ppn_t m;
        m = '1;
        m = ~(m << (int'(lvl) * LVL_BITS));
        return m;
    endfunction

endpackage

// File: rtl/xlat_vpn_cmp.sv
module xlat_vpn_cmp
    import xlat_pkg::*;
(
    input  vpn_t ent_vpn,
    input  lvl_t ent_lvl,
    input  vpn_t probe_vpn,
    output logic same_region
);
    vpn_t keep;

    assign keep        = upper_vpn_mask(ent_lvl);
    assign same_region = ((ent_vpn ^ probe_vpn) & keep) == '0;

endmodule

// File: rtl/xlat_pa_merge.sv
module xlat_pa_merge
    import xlat_pkg::*;
(
    input  ppn_t ent_ppn,
    input  lvl_t ent_lvl,
    input  vpn_t probe_vpn,
    input  ofs_t probe_ofs,
    output pa_t  pa
);
    ppn_t from_probe;
    ppn_t probe_wide;

    assign from_probe = low_ppn_mask(ent_lvl);
    assign probe_wide = PPN_W'(probe_vpn);
    assign pa = {(ent_ppn & ~from_probe) | (probe_wide & from_probe), probe_ofs};

endmodule

// File: rtl/xlat_slot_cache.sv
module xlat_slot_cache
    import xlat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ASID_W-1:0]   lk_asid,
    input  logic [VA_W-1:0]     lk_va,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_idx,
    output logic [PA_W-1:0]     hit_pa,
    output logic [ASID_W-1:0]   hit_asid,
    output logic                hit_global,
    output logic [VA_W-1:0]     hit_va,
    output logic [PA_W-1:0]     hit_leaf_pa,
    output logic [PTE_W-1:0]    hit_pte,
    output logic [LVL_W-1:0]    hit_level,
    output logic [PA_W-1:0]     hit_pte_addr,
    input  logic                ins_en,
    input  logic [ASID_W-1:0]   ins_asid,
    input  logic                ins_global,
    input  logic [VA_W-1:0]     ins_va,
    input  logic [PA_W-1:0]     ins_pa,
    input  logic [PTE_W-1:0]    ins_pte,
    input  logic [LVL_W-1:0]    ins_level,
    input  logic [PA_W-1:0]     ins_pte_addr,
    input  logic                fl_en,
    input  logic                fl_asid_vld,
    input  logic [ASID_W-1:0]   fl_asid,
    input  logic                fl_vpn_vld,
    input  logic [VPN_W-1:0]    fl_vpn
);
    logic      slot_valid;
    xlat_ent_t ent_q;
    xlat_ent_t ins_ent;

    logic      lk_region;
    logic      fl_region;
    logic      lk_match;
    logic      fl_asid_ok;
    logic      fl_match;
    fl_kind_e  fl_kind;
    pa_t       merged_pa;

    assign ins_ent = '{asid: ins_asid, glb: ins_global, va: ins_va, pa: ins_pa,
                       pte: ins_pte, lvl: ins_level, pte_addr: ins_pte_addr};

    // slot storage: install has priority over invalidation
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid <= 1'b0;
            ent_q      <= '0;
        end else if (ins_en) begin
            slot_valid <= 1'b1;
            ent_q      <= ins_ent;
        end else if (fl_en && fl_match) begin
            slot_valid <= 1'b0;
        end
    end

    // probe path
    xlat_vpn_cmp u_lk_cmp (
        .ent_vpn     (ent_q.va[VA_W-1:OFS_W]),
        .ent_lvl     (ent_q.lvl),
        .probe_vpn   (lk_va[VA_W-1:OFS_W]),
        .same_region (lk_region)
    );

    xlat_pa_merge u_merge (
        .ent_ppn   (ent_q.pa[PA_W-1:OFS_W]),
        .ent_lvl   (ent_q.lvl),
        .probe_vpn (lk_va[VA_W-1:OFS_W]),
        .probe_ofs (lk_va[OFS_W-1:0]),
        .pa        (merged_pa)
    );

    assign lk_match = slot_valid && lk_region && (ent_q.glb || (ent_q.asid == lk_asid));

    always_comb begin
        hit          = lk_match;
        hit_idx      = '0;
        hit_pa       = '0;
        hit_asid     = '0;
        hit_global   = 1'b0;
        hit_va       = '0;
        hit_leaf_pa  = '0;
        hit_pte      = '0;
        hit_level    = '0;
        hit_pte_addr = '0;
        if (lk_match) begin
            hit_pa       = merged_pa;
            hit_asid     = ent_q.asid;
            hit_global   = ent_q.glb;
            hit_va       = ent_q.va;
            hit_leaf_pa  = ent_q.pa;
            hit_pte      = ent_q.pte;
            hit_level    = ent_q.lvl;
            hit_pte_addr = ent_q.pte_addr;
        end
    end

    // invalidation filter
    xlat_vpn_cmp u_fl_cmp (
        .ent_vpn     (ent_q.va[VA_W-1:OFS_W]),
        .ent_lvl     (ent_q.lvl),
        .probe_vpn   (fl_vpn),
        .same_region (fl_region)
    );

    assign fl_asid_ok = !ent_q.glb && (ent_q.asid == fl_asid);
    assign fl_kind    = fl_kind_e'({fl_asid_vld, fl_vpn_vld});

    always_comb begin
        unique case (fl_kind)
            FL_ALL:  fl_match = 1'b1;
            FL_ASID: fl_match = fl_asid_ok;
            FL_VPN:  fl_match = fl_region;
            FL_BOTH: fl_match = fl_asid_ok && fl_region;
            default: fl_match = 1'b0;
        endcase
    end

endmodule

// File: rtl/xlat_slot_checker.sv
module xlat_slot_checker
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              slot_valid,
    input logic              slot_global,
    input logic              ins_en,
    input logic              fl_en,
    input logic              fl_asid_vld,
    input logic              fl_vpn_vld,
    input logic [ASID_W-1:0] lk_asid,
    input logic [VA_W-1:0]   lk_va,
    input logic              hit,
    input logic [PA_W-1:0]   hit_pa,
    input logic [ASID_W-1:0] hit_asid,
    input logic              hit_global,
    input logic [VA_W-1:0]   hit_va,
    input logic [PA_W-1:0]   hit_leaf_pa,
    input logic [PTE_W-1:0]  hit_pte,
    input logic [LVL_W-1:0]  hit_level,
    input logic [PA_W-1:0]   hit_pte_addr
);

    p_reset_clears_r1: assert property (@(posedge clk) rst |=> !hit);

    p_install_fills_r2: assert property (@(posedge clk) disable iff (rst)
        ins_en |=> slot_valid);

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (!ins_en && !fl_en) |=> $stable(slot_valid));

    p_hit_match_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> (slot_valid && (hit_global || hit_asid == lk_asid)));

    p_miss_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_pa == '0 && hit_asid == '0 && !hit_global && hit_va == '0 &&
                  hit_leaf_pa == '0 && hit_pte == '0 && hit_level == '0 &&
                  hit_pte_addr == '0));

    p_hit_offset_r5: assert property (@(posedge clk) disable iff (rst)
        hit |-> hit_pa[OFS_W-1:0] == lk_va[OFS_W-1:0]);

    p_open_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (fl_en && !fl_asid_vld && !fl_vpn_vld && !ins_en) |=> !slot_valid);

    p_global_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (fl_en && fl_asid_vld && !fl_vpn_vld && !ins_en && slot_valid && slot_global)
        |=> slot_valid);

    p_install_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (ins_en && fl_en) |=> slot_valid);

endmodule

bind xlat_slot_cache xlat_slot_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .slot_valid   (slot_valid),
    .slot_global  (ent_q.glb),
    .ins_en       (ins_en),
    .fl_en        (fl_en),
    .fl_asid_vld  (fl_asid_vld),
    .fl_vpn_vld   (fl_vpn_vld),
    .lk_asid      (lk_asid),
    .lk_va        (lk_va),
    .hit          (hit),
    .hit_pa       (hit_pa),
    .hit_asid     (hit_asid),
    .hit_global   (hit_global),
    .hit_va       (hit_va),
    .hit_leaf_pa  (hit_leaf_pa),
    .hit_pte      (hit_pte),
    .hit_level    (hit_level),
    .hit_pte_addr (hit_pte_addr)
);

// File: tb/test_xlat_slot_cache.sv
`timescale 1ns/1ps
module test_xlat_slot_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lk_asid = '0;
    logic [47:0] lk_va = '0;
    logic        hit;
    logic [0:0]  hit_idx;
    logic [55:0] hit_pa;
    logic [15:0] hit_asid;
    logic        hit_global;
    logic [47:0] hit_va;
    logic [55:0] hit_leaf_pa;
    logic [63:0] hit_pte;
    logic [1:0]  hit_level;
    logic [55:0] hit_pte_addr;
    logic        ins_en = 1'b0;
    logic [15:0] ins_asid = '0;
    logic        ins_global = 1'b0;
    logic [47:0] ins_va = '0;
    logic [55:0] ins_pa = '0;
    logic [63:0] ins_pte = '0;
    logic [1:0]  ins_level = '0;
    logic [55:0] ins_pte_addr = '0;
    logic        fl_en = 1'b0;
    logic        fl_asid_vld = 1'b0;
    logic [15:0] fl_asid = '0;
    logic        fl_vpn_vld = 1'b0;
    logic [35:0] fl_vpn = '0;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [15:0] ASA = 16'h00A1;
    localparam logic [15:0] ASB = 16'h0B02;
    localparam logic [47:0] V1  = 48'h7F12_3456_7ABC;
    localparam logic [55:0] P1  = 56'h00_0012_3456_7000;
    localparam logic [63:0] T1  = 64'h0000_0000_1234_56CF;
    localparam logic [55:0] A1  = 56'h00_0000_8000_1000;
    localparam logic [47:0] V2  = 48'h0040_1234_5678;
    localparam logic [55:0] P2  = 56'h00_00C0_4000_0000;
    localparam logic [63:0] T2  = 64'h0000_0000_3010_00CF;
    localparam logic [47:0] V3  = 48'h0000_8020_0345;
    localparam logic [55:0] P3  = 56'h00_0001_0020_0000;
    localparam logic [63:0] T3  = 64'h0000_0000_0400_80EF;

    always #10 clk = ~clk;

    xlat_slot_cache i_xlat_slot_cache (
        .clk(clk), .rst(rst), .lk_asid(lk_asid), .lk_va(lk_va),
        .hit(hit), .hit_idx(hit_idx), .hit_pa(hit_pa), .hit_asid(hit_asid),
        .hit_global(hit_global), .hit_va(hit_va), .hit_leaf_pa(hit_leaf_pa),
        .hit_pte(hit_pte), .hit_level(hit_level), .hit_pte_addr(hit_pte_addr),
        .ins_en(ins_en), .ins_asid(ins_asid), .ins_global(ins_global),
        .ins_va(ins_va), .ins_pa(ins_pa), .ins_pte(ins_pte),
        .ins_level(ins_level), .ins_pte_addr(ins_pte_addr),
        .fl_en(fl_en), .fl_asid_vld(fl_asid_vld), .fl_asid(fl_asid),
        .fl_vpn_vld(fl_vpn_vld), .fl_vpn(fl_vpn)
    );

    function automatic logic [55:0] ref_pa(input logic [55:0] spa, input int lvl,
                                           input logic [47:0] va);
        logic [43:0] ppn;
        logic [43:0] low;
        ppn = spa[55:12];
        low = (44'd1 << (lvl * 9)) - 44'd1;
        return {(ppn & ~low) | ({8'd0, va[47:12]} & low), va[11:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic probe(input logic [15:0] asid, input logic [47:0] va);
        lk_asid = asid;
        lk_va   = va;
        #1;
    endtask

    task automatic expect_hit(input string req, input logic [15:0] asid,
                              input logic [47:0] va, input logic [55:0] pa,
                              input logic [63:0] pte);
        probe(asid, va);
        check(req, "hit", 64'(hit), 64'd1);
        check(req, "pa", 64'(hit_pa), 64'(pa));
        check(req, "pte", hit_pte, pte);
    endtask

    task automatic expect_miss(input string req, input logic [15:0] asid,
                               input logic [47:0] va);
        probe(asid, va);
        check(req, "hit", 64'(hit), 64'd0);
        check(req, "pa", 64'(hit_pa), 64'd0);
        check(req, "pte", hit_pte, 64'd0);
    endtask

    task automatic put(input logic [15:0] asid, input logic glb, input logic [47:0] va,
                       input logic [55:0] pa, input logic [63:0] pte,
                       input logic [1:0] lvl, input logic [55:0] paddr);
        ins_asid = asid; ins_global = glb; ins_va = va; ins_pa = pa;
        ins_pte = pte; ins_level = lvl; ins_pte_addr = paddr; ins_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ins_en = 1'b0;
    endtask

    task automatic inval(input logic av, input logic [15:0] asid,
                         input logic vv, input logic [35:0] vpn);
        fl_asid_vld = av; fl_asid = asid; fl_vpn_vld = vv; fl_vpn = vpn; fl_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fl_en = 1'b0;
    endtask

    task automatic t_reset_state();
        expect_miss("R1", ASA, V1);
        check("R4", "hit_va", 64'(hit_va), 64'd0);
        check("R4", "hit_pte_addr", 64'(hit_pte_addr), 64'd0);
    endtask

    task automatic t_leaf_lookup();
        put(ASA, 1'b0, V1, P1, T1, 2'd0, A1);
        expect_hit("R2", ASA, V1, 56'h00_0012_3456_7ABC, T1);
        check("R3", "idx", 64'(hit_idx), 64'd0);
        check("R3", "asid", 64'(hit_asid), 64'(ASA));
        check("R3", "va", 64'(hit_va), 64'(V1));
        check("R3", "leaf_pa", 64'(hit_leaf_pa), 64'(P1));
        check("R3", "pte_addr", 64'(hit_pte_addr), 64'(A1));
        check("R3", "level", 64'(hit_level), 64'd0);
        expect_miss("R3", ASB, V1);
        expect_miss("R3", ASA, V1 ^ 48'h1000);
        expect_hit("R5", ASA, {V1[47:12], 12'h005}, 56'h00_0012_3456_7005, T1);
    endtask

    task automatic t_superpage();
        logic [47:0] vx;
        put(ASA, 1'b0, V2, P2, T2, 2'd2, A1);
        vx = V2 ^ 48'h0000_0ABC_D321;
        expect_hit("R5", ASA, vx, ref_pa(P2, 2, vx), T2);
        check("R5", "level", 64'(hit_level), 64'd2);
        expect_miss("R3", ASA, V2 ^ 48'h0000_4000_0000);
    endtask

    task automatic t_global();
        put(ASA, 1'b1, V3, P3, T3, 2'd1, A1);
        expect_hit("R3", ASB, V3, ref_pa(P3, 1, V3), T3);
        check("R3", "global", 64'(hit_global), 64'd1);
    endtask

    task automatic t_replace();
        put(ASA, 1'b0, V1, P1, T1, 2'd0, A1);
        put(ASB, 1'b0, V2, P2, T2, 2'd0, A1);
        expect_miss("R2", ASA, V1);
        expect_hit("R2", ASB, V2, {P2[55:12], V2[11:0]}, T2);
    endtask

    task automatic t_flush_all();
        put(ASA, 1'b1, V1, P1, T1, 2'd0, A1);
        inval(1'b0, ASB, 1'b0, 36'h0);
        expect_miss("R6", ASA, V1);
    endtask

    task automatic t_flush_asid();
        put(ASA, 1'b0, V1, P1, T1, 2'd0, A1);
        inval(1'b1, ASB, 1'b0, 36'h0);
        expect_hit("R7", ASA, V1, {P1[55:12], V1[11:0]}, T1);
        inval(1'b1, ASA, 1'b0, 36'h0);
        expect_miss("R7", ASA, V1);
        put(ASA, 1'b1, V1, P1, T1, 2'd0, A1);
        inval(1'b1, ASA, 1'b0, 36'h0);
        expect_hit("R7", ASA, V1, {P1[55:12], V1[11:0]}, T1);
    endtask

    task automatic t_flush_addr();
        put(ASA, 1'b1, V3, P3, T3, 2'd1, A1);
        inval(1'b0, ASB, 1'b1, V3[47:12] ^ 36'h200);
        expect_hit("R8", ASA, V3, ref_pa(P3, 1, V3), T3);
        inval(1'b0, ASB, 1'b1, V3[47:12] ^ 36'h1F1);
        expect_miss("R8", ASA, V3);
    endtask

    task automatic t_flush_both();
        put(ASA, 1'b0, V1, P1, T1, 2'd0, A1);
        inval(1'b1, ASA, 1'b1, V1[47:12] ^ 36'h1);
        expect_hit("R9", ASA, V1, {P1[55:12], V1[11:0]}, T1);
        inval(1'b1, ASB, 1'b1, V1[47:12]);
        expect_hit("R9", ASA, V1, {P1[55:12], V1[11:0]}, T1);
        inval(1'b1, ASA, 1'b1, V1[47:12]);
        expect_miss("R9", ASA, V1);
        put(ASA, 1'b1, V1, P1, T1, 2'd0, A1);
        inval(1'b1, ASA, 1'b1, V1[47:12]);
        expect_hit("R9", ASA, V1, {P1[55:12], V1[11:0]}, T1);
    endtask

    task automatic t_install_vs_flush();
        fl_asid_vld = 1'b0; fl_vpn_vld = 1'b0; fl_en = 1'b1;
        put(ASB, 1'b0, V2, P2, T2, 2'd0, A1);
        fl_en = 1'b0;
        expect_hit("R10", ASB, V2, {P2[55:12], V2[11:0]}, T2);
    endtask

    task automatic t_reset_midrun();
        put(ASA, 1'b0, V1, P1, T1, 2'd0, A1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_miss("R1", ASA, V1);
    endtask

    initial begin
        #4_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_leaf_lookup();
        t_superpage();
        t_global();
        t_replace();
        t_flush_all();
        t_flush_asid();
        t_flush_addr();
        t_flush_both();
        t_install_vs_flush();
        t_reset_midrun();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule